// File: doc/BRIEF.md
# Half-Duplex Command/Response Serial Master

This block is a serial master for a message-passing link in which every frame is half duplex. A frame opens by lowering an active-low frame strobe, shifts out an 8-bit command word MSB first, leaves one serial clock as a turnaround so the slave can decode the command, and then clocks in a response of programmable length, also MSB first. The response length is 4 to 16 bits, so a frame spans 13 to 25 serial clocks.

A host offers a command on `cmd_data` with `cmd_valid`. The block takes it when `cmd_ready` is high. The response length and the clock divider are captured at the same moment. The serial clock idles low. The master changes its transmit bit on falling edges and samples the receive line on rising edges. At the end of the frame the strobe returns high, and a one-cycle `rsp_done` pulse presents the response right-aligned on `rsp_data`.

Top module: `hdx_cmd_master`

## Requirements
- R1: After reset and whenever the block is idle: `cmd_ready` is 1, `sck` is 0, `frame_n` is 1 and `sdo` is 0. Right after reset, `rsp_done` is 0 and `rsp_data` is 0.
- R2: When `cmd_valid` is 1 while `cmd_ready` is 1 at a clock edge, the next cycle shows `frame_n` at 0 and `cmd_ready` at 0.
- R3: The command bits appear on `sdo` MSB first, bit 7 at the strobe fall. Each following bit appears on a falling `sck` edge. `sdo` never changes while `sck` is high, and it is 0 from the 9th serial clock to the end of the frame.
- R4: With divider setting D, every interval between consecutive `sck` transitions lasts D+1 clock cycles. This includes the interval from the strobe fall to the first rising edge and the interval to the final fall.
- R5: The response is sampled from `sdi` on the rising edges of serial clocks 10 through 9+N, first bit as MSB. `sdi` is ignored on clocks 1 to 8 (command) and on clock 9 (turnaround).
- R6: The effective response length N is `rsp_len` clamped to the range 4..16: a value below 4 gives 4 and a value above 16 gives 16.
- R7: A frame has exactly 9+N rising `sck` edges. `frame_n` stays low for exactly 2*(9+N)*(D+1) cycles. `sck` is 0 whenever `frame_n` is 1.
- R8: `rsp_done` is a one-cycle pulse in the first cycle with `frame_n` high again. At that point `rsp_data` bits N-1..0 hold the response (the first received bit in bit N-1) and the upper bits are 0.
- R9: `rsp_data` changes only in a cycle where `rsp_done` is 1.
- R10: While a frame runs, changes on `cmd_valid`, `cmd_data`, `rsp_len` and `div_half` do not alter the frame in progress and do not queue a new one.
- R11: `cmd_ready` is 1 in the `rsp_done` cycle. A `cmd_valid` held high then starts the next frame at the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Block idle; command accepted when both are high |
| cmd_data | input | 8 | Command word, sent MSB first |
| rsp_len | input | LEN_W | Requested response length in bits (clamped 4..16) |
| div_half | input | DIV_W | Serial half-period length minus one, in clock cycles |
| sck | output | 1 | Serial clock, idle low |
| frame_n | output | 1 | Active-low frame strobe |
| sdo | output | 1 | Serial data to the slave |
| sdi | input | 1 | Serial data from the slave |
| rsp_done | output | 1 | One-cycle end-of-frame pulse |
| rsp_data | output | MAX_RSP | Last response, right-aligned |

## Verification
The bench builds the block with a 4-bit divider field and the default 4..16 response window. This puts both the fastest half period (D=0) and the slowest (D=15) within a few hundred cycles per frame. The 5-bit length field can still carry values below 4 and above 16, so both sides of the clamp are reached. The minimum, a mid-range and the maximum response lengths are each run. The slave model drives random values on `sdi` during the command and turnaround clocks, so any early sample would corrupt the response.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  localparam int CMD_BITS = 8;
  localparam int TURN_CYC = 1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } hdx_state_e;
endpackage

// File: rtl/hdx_tick_gen.sv
module hdx_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             tick
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q;
    tick  = run && (cnt_q == div_q);
    if (load) begin
      div_d = div_in;
      cnt_d = '0;
    end else if (run) begin
      cnt_d = tick ? '0 : cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/hdx_tx_shift.sv
module hdx_tx_shift import hdx_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CMD_BITS-1:0] cmd_in,
  input  logic                adv,
  output logic                sdo
);
  logic [CMD_BITS-1:0] sh_q, sh_d;
  logic                sdo_q, sdo_d;

  // Zeros enter from the right, so the line drops low once the command is out.
  always_comb begin
    sh_d  = sh_q;
    sdo_d = sdo_q;
    if (load) begin
      sdo_d = cmd_in[CMD_BITS-1];
      sh_d  = {cmd_in[CMD_BITS-2:0], 1'b0};
    end else if (adv) begin
      sdo_d = sh_q[CMD_BITS-1];
      sh_d  = {sh_q[CMD_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      sdo_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      sdo_q <= sdo_d;
    end
  end

  assign sdo = sdo_q;
endmodule

// File: rtl/hdx_rx_shift.sv
module hdx_rx_shift #(
  parameter int MAX_RSP = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               cap,
  input  logic               sdi,
  input  logic               fin,
  output logic [MAX_RSP-1:0] rsp_data
);
  logic [MAX_RSP-1:0] sh_q, sh_d;
  logic [MAX_RSP-1:0] out_q, out_d;

  always_comb begin
    sh_d  = sh_q;
    out_d = out_q;
    if (clear)    sh_d = '0;
    else if (cap) sh_d = {sh_q[MAX_RSP-2:0], sdi};
    if (fin)      out_d = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      out_q <= '0;
    end else begin
      sh_q  <= sh_d;
      out_q <= out_d;
    end
  end

  assign rsp_data = out_q;
endmodule

// File: rtl/hdx_frame_ctl.sv
module hdx_frame_ctl import hdx_pkg::*; #(
  parameter int MIN_RSP = 4,
  parameter int MAX_RSP = 16,
  parameter int LEN_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [LEN_W-1:0] len_in,
  input  logic             tick,
  output logic             cmd_ready,
  output logic             start,
  output logic             run,
  output logic             adv,
  output logic             cap,
  output logic             fin,
  output logic             sck,
  output logic             frame_n,
  output logic             done
);
  localparam int CYC_W = $clog2(CMD_BITS + TURN_CYC + MAX_RSP + 1);
  localparam logic [CYC_W-1:0] FIRST_CAP = CYC_W'(CMD_BITS + TURN_CYC);
  localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(MIN_RSP);
  localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(MAX_RSP);

  hdx_state_e       state_q, state_d;
  logic             ph_q, ph_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             sck_q, sck_d;
  logic             frm_q, frm_d;
  logic             done_q, done_d;
  logic [LEN_W-1:0] len_eff;
  logic [CYC_W-1:0] last_cyc;
  logic             rise, fall;

  always_comb begin
    len_eff = len_in;
    if (len_in < LEN_LO)      len_eff = LEN_LO;
    else if (len_in > LEN_HI) len_eff = LEN_HI;

    run       = (state_q == ST_RUN);
    cmd_ready = (state_q == ST_IDLE);
    start     = cmd_ready && cmd_valid;
    rise      = run && tick && !ph_q;
    fall      = run && tick && ph_q;
    last_cyc  = FIRST_CAP + CYC_W'(len_q);
    fin       = fall && (cyc_q == last_cyc);
    cap       = rise && (cyc_q >= FIRST_CAP);
    adv       = fall && !fin;

    state_d = state_q;
    ph_d    = ph_q;
    cyc_d   = cyc_q;
    len_d   = len_q;
    sck_d   = sck_q;
    frm_d   = frm_q;
    done_d  = fin;
    if (start) begin
      state_d = ST_RUN;
      ph_d    = 1'b0;
      cyc_d   = '0;
      len_d   = len_eff;
      sck_d   = 1'b0;
      frm_d   = 1'b0;
    end else if (rise) begin
      ph_d  = 1'b1;
      sck_d = 1'b1;
      cyc_d = cyc_q + CYC_W'(1);
    end else if (fall) begin
      ph_d  = 1'b0;
      sck_d = 1'b0;
      if (fin) begin
        state_d = ST_IDLE;
        frm_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= 1'b0;
      cyc_q   <= '0;
      len_q   <= LEN_LO;
      sck_q   <= 1'b0;
      frm_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      cyc_q   <= cyc_d;
      len_q   <= len_d;
      sck_q   <= sck_d;
      frm_q   <= frm_d;
      done_q  <= done_d;
    end
  end

  assign sck     = sck_q;
  assign frame_n = frm_q;
  assign done    = done_q;
endmodule

// File: rtl/hdx_cmd_master.sv
module hdx_cmd_master import hdx_pkg::*; #(
  parameter int MIN_RSP = 4,
  parameter int MAX_RSP = 16,
  parameter int DIV_W   = 8,
  parameter int LEN_W   = $clog2(MAX_RSP + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [CMD_BITS-1:0] cmd_data,
  input  logic [LEN_W-1:0]    rsp_len,
  input  logic [DIV_W-1:0]    div_half,
  output logic                sck,
  output logic                frame_n,
  output logic                sdo,
  input  logic                sdi,
  output logic                rsp_done,
  output logic [MAX_RSP-1:0]  rsp_data
);
  logic start, run, adv, cap, fin, tick;

  hdx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .load(start), .div_in(div_half),
    .run(run), .tick(tick)
  );

  hdx_frame_ctl #(.MIN_RSP(MIN_RSP), .MAX_RSP(MAX_RSP), .LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .len_in(rsp_len),
    .tick(tick), .cmd_ready(cmd_ready), .start(start), .run(run),
    .adv(adv), .cap(cap), .fin(fin), .sck(sck), .frame_n(frame_n),
    .done(rsp_done)
  );

  hdx_tx_shift u_tx (
    .clk(clk), .rst_n(rst_n), .load(start), .cmd_in(cmd_data),
    .adv(adv), .sdo(sdo)
  );

  hdx_rx_shift #(.MAX_RSP(MAX_RSP)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(start), .cap(cap), .sdi(sdi),
    .fin(fin), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/hdx_cmd_master_chk.sv
module hdx_cmd_master_chk #(
  parameter int MAX_RSP = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic               sck,
  input logic               frame_n,
  input logic               sdo,
  input logic               rsp_done,
  input logic [MAX_RSP-1:0] rsp_data
);
  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!sck && frame_n && !sdo));

  a_r2_strobe_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!frame_n && !cmd_ready));

  a_r3_sdo_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(sdo));

  a_r7_clk_low_outside: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n |-> !sck);

  a_r8_done_at_strobe_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_n) |-> rsp_done);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_done |-> $stable(rsp_data));

  a_r11_ready_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> cmd_ready);
endmodule

bind hdx_cmd_master hdx_cmd_master_chk #(.MAX_RSP(MAX_RSP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .sck(sck), .frame_n(frame_n), .sdo(sdo), .rsp_done(rsp_done),
  .rsp_data(rsp_data)
);

// File: tb/tb_hdx_cmd_master.sv
`timescale 1ns/1ps
module tb_hdx_cmd_master;
  localparam int DIV_W   = 4;
  localparam int MIN_RSP = 4;
  localparam int MAX_RSP = 16;
  localparam int LEN_W   = 5;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               cmd_valid;
  logic               cmd_ready;
  logic [7:0]         cmd_data;
  logic [LEN_W-1:0]   rsp_len;
  logic [DIV_W-1:0]   div_half;
  logic               sck, frame_n, sdo, sdi, rsp_done;
  logic [MAX_RSP-1:0] rsp_data;

  int vecs = 0;
  int errs = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hdx_cmd_master #(.MIN_RSP(MIN_RSP), .MAX_RSP(MAX_RSP), .DIV_W(DIV_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .rsp_len(rsp_len), .div_half(div_half),
    .sck(sck), .frame_n(frame_n), .sdo(sdo), .sdi(sdi),
    .rsp_done(rsp_done), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // One frame with a slave model; all timing is observed at falling clk edges.
  task automatic frame(input logic [7:0] cmd, input int len_set, input int dv,
                       input logic [15:0] resp, input bit hold, input bit perturb);
    int n, i, tlast, rises, falls, low, bad_int;
    logic prev;
    logic [7:0] got;
    logic [15:0] expd;
    bit sdo_bad;
    n = (len_set < MIN_RSP) ? MIN_RSP : (len_set > MAX_RSP) ? MAX_RSP : len_set;
    expd = resp & 16'((32'd1 << n) - 1);
    cmd_data = cmd; rsp_len = LEN_W'(len_set); div_half = DIV_W'(dv);
    cmd_valid = 1'b1; sdi = 1'($urandom_range(0, 1));
    @(negedge clk);
    chk(!frame_n && !cmd_ready, "R2 accept", {frame_n, cmd_ready}, 0);
    chk(sdo == cmd[7], "R3 first bit at strobe", sdo, cmd[7]);
    if (!hold) cmd_valid = 1'b0;
    i = 1; tlast = 1; rises = 0; falls = 0; low = 1; bad_int = 0;
    prev = 1'b0; got = '0; sdo_bad = 0;
    forever begin
      if (perturb && i == 3) begin
        cmd_data = ~cmd; rsp_len = LEN_W'(5); div_half = DIV_W'(dv + 1); cmd_valid = 1'b1;
      end
      if (perturb && i == 6) cmd_valid = hold;
      @(negedge clk); i++;
      if (sck != prev) begin
        if (i - tlast != dv + 1) bad_int++;
        tlast = i; prev = sck;
        if (sck) begin
          rises++;
          if (rises <= 8) got = {got[6:0], sdo};
          else if (sdo) sdo_bad = 1;
        end else begin
          falls++;
          if (falls >= 9 && falls - 9 < n) sdi = resp[n - 1 - (falls - 9)];
          else sdi = 1'($urandom_range(0, 1));
        end
      end
      if (frame_n) break;
      low++;
    end
    chk(got == cmd, "R3 command bits", got, cmd);
    chk(!sdo_bad, "R3 sdo low after command", sdo_bad, 0);
    chk(bad_int == 0, "R4 half-period length", bad_int, 0);
    chk(rises == 9 + n, "R7 rising edges", rises, 9 + n);
    chk(low == 2 * (9 + n) * (dv + 1), "R7 strobe low cycles", low, 2 * (9 + n) * (dv + 1));
    chk(rsp_done == 1'b1, "R8 done with strobe rise", rsp_done, 1);
    chk(rsp_data == expd, "R5 R6 R8 response word", rsp_data, expd);
    chk(cmd_ready == 1'b1, "R11 ready in done cycle", cmd_ready, 1);
    if (perturb) chk(rsp_data == expd && rises == 9 + n, "R10 busy changes ignored", rsp_data, expd);
    if (!hold) begin
      @(negedge clk);
      chk(!rsp_done, "R8 done one cycle", rsp_done, 0);
      chk(rsp_data == expd, "R9 response held", rsp_data, expd);
      chk(frame_n && !sck && !sdo && cmd_ready, "R1 idle after frame", {frame_n, sck, sdo, cmd_ready}, 4'b1001);
      repeat (3) @(negedge clk);
      chk(rsp_data == expd, "R9 response held idle", rsp_data, expd);
      chk(frame_n, "R10 no queued frame", frame_n, 1);
    end
  endtask

  task automatic t_reset();
    chk(cmd_ready && !sck && frame_n && !sdo, "R1 reset lines", {cmd_ready, sck, frame_n, sdo}, 4'b1010);
    chk(!rsp_done && rsp_data == '0, "R1 reset outputs", {rsp_done, rsp_data}, 0);
  endtask

  task automatic t_basic();
    frame(8'hA5, 8, 0, 16'h00C3, 0, 0);
    frame(8'h3C, 12, 1, 16'h0B71, 0, 0);
  endtask

  task automatic t_lengths();
    frame(8'h81, 4, 2, 16'h0009, 0, 0);
    frame(8'h7E, 16, 0, 16'hD2E7, 0, 0);
  endtask

  task automatic t_clamp();
    frame(8'h5A, 2, 0, 16'h000E, 0, 0);
    frame(8'hC7, 20, 1, 16'h9A3B, 0, 0);
  endtask

  task automatic t_divider();
    frame(8'hF0, 6, 15, 16'h002D, 0, 0);
    frame(8'h0F, 9, 3, 16'h01A5, 0, 0);
  endtask

  task automatic t_ignore();
    frame(8'h96, 10, 2, 16'h02C9, 0, 1);
  endtask

  task automatic t_backtoback();
    frame(8'h12, 5, 0, 16'h0015, 1, 0);
    frame(8'hED, 7, 1, 16'h004B, 0, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = '0; rsp_len = LEN_W'(8);
    div_half = '0; sdi = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_lengths();
    t_clamp();
    t_divider();
    t_ignore();
    t_backtoback();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      vecs++; errs++;
      $display("FAIL watchdog R1 act=%0h exp=%0h", 0, 1);
      summary();
      $finish;
    end
  end
endmodule